// File: doc/BRIEF.md
# Serial-Programmed Clock Fan-Out Enable Controller

This block distributes one reference clock to ten output lines and lets a host switch each line on or off over a two-wire serial bus. The serial side only ever receives. It frames transfers with START and STOP conditions and matches a fixed write address. After the address it accepts two filler bytes, then a run of enable bytes. Its only drive onto the data line is the low pulse that acknowledges a byte.

The serial lines are oversampled in the reference clock domain. The written enable bits pass through a second register stage that is clocked on the falling reference edge. The gating therefore only changes while the clock is low. A global output-enable pin drives the tri-state control of every output, whatever the serial enable bits hold.

Top module: `clkfan_ctrl`

## Requirements
- R1: A falling data edge while the serial clock is high starts a transfer, and a rising data edge while the serial clock is high ends it. Bytes are 8 bits, most significant bit first. An accepted byte is acknowledged by holding the data line low for the whole ninth clock pulse.
- R2: Only the first byte 0xD2 (7-bit address 0x69, direction bit 0 = write) is acknowledged. Any other first byte, including the read request 0xD3, gets no acknowledge. The rest of that transfer leaves the enables unchanged.
- R3: The two bytes after the address are acknowledged and their contents have no effect on any output.
- R4: Data byte 0 bit k (k = 0..7) enables output k, where 1 means enabled. Data byte 1 bits 0 and 1 enable outputs 8 and 9. Later data bytes are acknowledged and discarded. Outputs whose byte was not sent keep their setting.
- R5: An enabled output toggles as a copy of the reference clock. A disabled output stays low.
- R6: A change of enable takes effect only while the reference clock is low, so no output is high while the reference clock is low.
- R7: Reset enables all ten outputs.
- R8: When the output-enable pin is low, all ten tri-state controls are 0 (high impedance). When it is high, all ten are 1, whatever the enables hold.
- R9: A START inside a byte abandons that byte and restarts address reception. Enable bytes completed before it keep their new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock; source of all outputs and of the sampling logic |
| rst_i | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (resolved bus level) |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| oe_i | input | 1 | Global output enable, low forces high impedance |
| gclk_o | output | 10 | Gated copies of the reference clock |
| gclk_drive_o | output | 10 | Per-output tri-state control, 1 = drive |

## Verification
The bench builds the block with its defaults: ten outputs, address 0x69 and two synchronizer stages. Ten outputs need two enable bytes, so partial-byte updates, the kept upper bits and the discarded third data byte are all reachable. A serial half-period of eight reference cycles leaves the two-stage sampling latency well inside each bit. The bench can then sample acknowledges in the middle of the ninth pulse.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_ADDR, RX_CMD, RX_CNT, RX_DATA, RX_SKIP
  } rx_state_t;
endpackage

// File: rtl/clkfan_line_sync.sv
module clkfan_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;
  logic scl_s, sda_s;

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign sda_o   = sda_s;
  assign start_o = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_o  = scl_s & scl_prev & ~sda_prev & sda_s;
  assign rise_o  = scl_s & ~scl_prev;
  assign fall_o  = ~scl_s & scl_prev;
endmodule

// File: rtl/clkfan_byte_rx.sv
module clkfan_byte_rx
  import clkfan_pkg::*;
#(
  parameter int         NUM_OUT  = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               sda_i,
  output logic               ack_o,
  output logic [NUM_OUT-1:0] en_o
);
  localparam int NBYTES = (NUM_OUT + 7) / 8;
  localparam int IDX_W  = $clog2(NBYTES + 1);

  rx_state_t        state;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ack_o  <= 1'b0;
      idx    <= '0;
      en_o   <= '1;
    end else if (start_i) begin
      state  <= RX_ADDR;
      bitcnt <= '0;
      ack_o  <= 1'b0;
    end else if (stop_i) begin
      state  <= RX_IDLE;
      bitcnt <= '0;
      ack_o  <= 1'b0;
    end else begin
      if (rise_i && bitcnt < 4'd8 && state != RX_IDLE) begin
        shreg  <= {shreg[6:0], sda_i};
        bitcnt <= bitcnt + 4'd1;
      end
      if (fall_i) begin
        if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          unique case (state)
            RX_ADDR: begin
              if (shreg == {DEV_ADDR, 1'b0}) begin
                ack_o <= 1'b1;
                state <= RX_CMD;
              end else begin
                state <= RX_SKIP;
              end
            end
            RX_CMD: begin
              ack_o <= 1'b1;
              state <= RX_CNT;
            end
            RX_CNT: begin
              ack_o <= 1'b1;
              state <= RX_DATA;
              idx   <= '0;
            end
            RX_DATA: begin
              ack_o <= 1'b1;
              if (int'(idx) < NBYTES) begin
                for (int i = 0; i < NUM_OUT; i++)
                  if (int'(idx) == i / 8) en_o[i] <= shreg[i % 8];
                idx <= idx + 1'b1;
              end
            end
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          ack_o  <= 1'b0;
        end
      end
    end
  end

  // R2
  ack_state_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (state == RX_CMD || state == RX_CNT || state == RX_DATA));
  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_SKIP || state == RX_IDLE) |-> !ack_o);
  // R1
  ack_window_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (bitcnt == 4'd9));
  // R7
  rst_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&en_o));
endmodule

// File: rtl/clkfan_gate_bank.sv
module clkfan_gate_bank #(
  parameter int NUM_OUT = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] en_i,
  output logic [NUM_OUT-1:0] gclk_o
);
  logic [NUM_OUT-1:0] en_mid, en_lo;

  always_ff @(posedge clk) begin
    if (rst) en_mid <= '1;
    else     en_mid <= en_i;
  end

  always_ff @(negedge clk) begin
    if (rst) en_lo <= '1;
    else     en_lo <= en_mid;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    assign gclk_o[g] = clk & en_lo[g];
  end

  // R6
  lag_chk: assert property (@(posedge clk) disable iff (rst)
    en_lo == en_mid);
endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl #(
  parameter int         NUM_OUT  = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         STAGES   = 2
) (
  input  logic               clk_ref_i,
  input  logic               rst_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic               oe_i,
  output logic [NUM_OUT-1:0] gclk_o,
  output logic [NUM_OUT-1:0] gclk_drive_o
);
  logic sda_s, start_p, stop_p, rise_p, fall_p;
  logic [NUM_OUT-1:0] en_w;

  clkfan_line_sync #(.STAGES(STAGES)) i_sync (
    .clk(clk_ref_i), .rst(rst_i), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .start_o(start_p), .stop_o(stop_p),
    .rise_o(rise_p), .fall_o(fall_p));

  clkfan_byte_rx #(.NUM_OUT(NUM_OUT), .DEV_ADDR(DEV_ADDR)) i_rx (
    .clk(clk_ref_i), .rst(rst_i), .start_i(start_p), .stop_i(stop_p),
    .rise_i(rise_p), .fall_i(fall_p), .sda_i(sda_s),
    .ack_o(sda_pull_o), .en_o(en_w));

  clkfan_gate_bank #(.NUM_OUT(NUM_OUT)) i_gate (
    .clk(clk_ref_i), .rst(rst_i), .en_i(en_w), .gclk_o(gclk_o));

  assign gclk_drive_o = {NUM_OUT{oe_i}};
endmodule

// File: tb/test_clkfan_ctrl.sv
module test_clkfan_ctrl;
  localparam int CLK_P = 10;
  localparam int HB    = 8;
  localparam int N     = 10;
  // {data0, data1, expected enables}
  localparam logic [25:0] VEC [4] = '{
    {8'hFF, 8'h03, 10'h3FF},
    {8'h00, 8'h00, 10'h000},
    {8'hA5, 8'h02, 10'h2A5},
    {8'h5A, 8'hFD, 10'h15A}
  };

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_drv = 1'b1, oe = 1'b1;
  logic sda_pull;
  logic [N-1:0] gclk, gdrv;
  wire sda_bus = sda_drv & ~sda_pull;
  int n_chk = 0, n_bad = 0, runt = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  clkfan_ctrl i_clkfan_ctrl (
    .clk_ref_i(clk), .rst_i(rst), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .oe_i(oe), .gclk_o(gclk), .gclk_drive_o(gdrv));

  always @(gclk) if (!rst && (gclk & ~{N{clk}}) != '0) runt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HB) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; hw(); scl = 1'b1; hw(); sda_drv = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; hw(); scl = 1'b1; hw(); sda_drv = 1'b1; hw();
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0; hw();
    end
  endtask

  task automatic send_byte(logic [7:0] b, logic exp_ack, string req);
    logic got;
    send_bits(b, 8);
    sda_drv = 1'b1; hw(); scl = 1'b1; hw();
    got = ~sda_bus;
    scl = 1'b0; hw();
    chk(req, {31'b0, got}, {31'b0, exp_ack});
  endtask

  task automatic observe(output logic [N-1:0] seen);
    seen = '0;
    repeat (4) begin
      @(posedge clk); #1 seen |= gclk;
    end
  endtask

  task automatic check_en(string req, logic [N-1:0] exp);
    logic [N-1:0] seen;
    repeat (4) @(negedge clk);
    observe(seen);
    chk(req, {22'b0, seen}, {22'b0, exp});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R7 reset state: all outputs toggling
    check_en("R7 reset enables", 10'h3FF);
    chk("R1 no ack at idle", {31'b0, sda_pull}, 32'd0);
    // R8 drive on with oe high
    chk("R8 drive with oe high", {22'b0, gdrv}, {22'b0, 10'h3FF});

    // R4 R3 R1 table of full writes; command/count bytes carry junk
    foreach (VEC[v]) begin
      i2c_start();
      send_byte(8'hD2, 1'b1, "R1 R2 address ack");
      send_byte(8'h9C, 1'b1, "R3 command ack");
      send_byte(8'h55, 1'b1, "R3 count ack");
      send_byte(VEC[v][25:18], 1'b1, "R4 data0 ack");
      send_byte(VEC[v][17:10], 1'b1, "R4 data1 ack");
      i2c_stop();
      check_en("R4 R5 table enables", VEC[v][9:0]);
    end

    // R2 wrong address: no ack, no effect
    i2c_start();
    send_byte(8'hA0, 1'b0, "R2 foreign address nack");
    send_byte(8'h00, 1'b0, "R2 foreign byte nack");
    send_byte(8'h00, 1'b0, "R2 foreign byte nack");
    send_byte(8'h00, 1'b0, "R2 foreign byte nack");
    i2c_stop();
    check_en("R2 foreign address keeps enables", 10'h15A);

    // R2 read request 0xD3 not serviced
    i2c_start();
    send_byte(8'hD3, 1'b0, "R2 read nack");
    send_byte(8'hFF, 1'b0, "R2 read bus released");
    i2c_stop();
    check_en("R2 read keeps enables", 10'h15A);

    // R4 only first data byte: outputs 8,9 keep their value
    i2c_start();
    send_byte(8'hD2, 1'b1, "R1 address ack");
    send_byte(8'h00, 1'b1, "R3 command ack");
    send_byte(8'hFF, 1'b1, "R3 count ack");
    send_byte(8'h0F, 1'b1, "R4 data0 ack");
    i2c_stop();
    check_en("R4 short write keeps upper", 10'h10F);

    // R4 third data byte acknowledged and discarded
    i2c_start();
    send_byte(8'hD2, 1'b1, "R1 address ack");
    send_byte(8'h00, 1'b1, "R3 command ack");
    send_byte(8'h00, 1'b1, "R3 count ack");
    send_byte(8'hF0, 1'b1, "R4 data0 ack");
    send_byte(8'h02, 1'b1, "R4 data1 ack");
    send_byte(8'hFF, 1'b1, "R4 extra byte ack");
    i2c_stop();
    check_en("R4 extra byte discarded", 10'h2F0);

    // R9 START inside second data byte
    i2c_start();
    send_byte(8'hD2, 1'b1, "R1 address ack");
    send_byte(8'h00, 1'b1, "R3 command ack");
    send_byte(8'h00, 1'b1, "R3 count ack");
    send_byte(8'h33, 1'b1, "R4 data0 ack");
    send_bits(8'h01, 4);
    i2c_start();
    send_byte(8'hA0, 1'b0, "R9 restart expects address");
    i2c_stop();
    check_en("R9 abort keeps completed byte", 10'h233);

    // R8 oe low forces high impedance regardless of enables
    oe = 1'b0; #1;
    chk("R8 oe low tri-states all", {22'b0, gdrv}, 32'd0);
    oe = 1'b1; #1;
    chk("R8 oe high drives all", {22'b0, gdrv}, {22'b0, 10'h3FF});

    // R7 reset from a mixed state
    @(negedge clk); rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    check_en("R7 reset re-enables", 10'h3FF);

    // R6 no output high while reference low
    chk("R6 no runt", runt, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule